// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

A small stored-program processor built around one 16-bit accumulator. Each word is 16 bits wide, and a word address is 12 bits wide. Instructions are single words. Bits 15:12 hold the operation code and bits 11:0 hold an unsigned operand field X. A multicycle control machine runs a shared four-cycle fetch, decodes the operation code, and then steps through a short execute sequence for one of sixteen operations. All arithmetic is two's complement and wraps on overflow. No flag is raised.

The core drives a synchronous word-wide memory port: address, write data, write enable and read data. Read data is valid in the cycle after the address is presented. A write takes effect on the clock edge at which write enable is high. An 8-bit value comes in from outside, and an 8-bit output register is driven outward. A halted flag goes high once the halt operation (code 0) has executed. Because unwritten memory reads as zero, a program that runs past its end soon stops.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is low and in the first cycle after it, `halted` is 0, `mem_we` is 0, `out_data` is 0 and `mem_addr` is 0. The first instruction is fetched from address 0.
- R2: Each instruction takes a four-cycle fetch, during which the program counter is incremented, before execute begins. Counted from the start of fetch to the next fetch, an instruction takes the following cycles:
  - clear, input, output, skip, jump, add-immediate and subtract-immediate: 5 cycles
  - store: 6 cycles
  - load, add, subtract, jump-indirect and jump-and-store: 8 cycles
  - add-indirect and load-indirect: 11 cycles
- R3: Code 0 (halt) raises `halted` 5 cycles after its fetch begins. From then on no memory write occurs and `out_data` stays unchanged.
- R4: The direct operations act on M[X]:
  - load (code 1) sets AC = M[X]
  - store (code 2) writes AC to M[X]
  - add (code 3) sets AC = AC + M[X]
  - subtract (code 4) sets AC = AC - M[X]
  - all results wrap modulo 2^16
- R5: Add-indirect (code B) sets AC = AC + M[M[X][11:0]], and load-indirect (code D) sets AC = M[M[X][11:0]]. Each uses two memory reads.
- R6: Add-immediate (code E) and subtract-immediate (code F) combine AC with X, zero-extended to 16 bits, and wrap.
- R7: Skip (code 8) adds 1 more to the program counter according to bits 11:10:
  - 00: when AC[15] is 1 (negative)
  - 01: when AC is 0
  - 10: when AC is nonzero and AC[15] is 0 (positive)
  - 11: never
- R8: Jump (code 9) sets the program counter to X. Jump-indirect (code C) sets it to M[X][11:0].
- R9: Jump-and-store (code 7) writes the return address (the address after the call) to M[X]. It then leaves AC = X+1 and continues at X+1.
- R10: Input (code 5) sets AC to `in_data` zero-extended. Output (code 6) copies AC[7:0] to `out_data`. Clear (code A) sets AC to 0. `out_data` changes only through output.
- R11: Every write lasts exactly one cycle, with `mem_addr` and `mem_wdata` valid in that cycle. Writes occur in program order, with the address and data that the operations define.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 12 | Word address to memory |
| mem_wdata | output | 16 | Data to be written |
| mem_we | output | 1 | Write enable, one cycle per write |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| in_data | input | 8 | External input value |
| out_data | output | 8 | Output register |
| halted | output | 1 | High once halt has executed |

## Verification
Four short programs are run against a behavioural instruction-level model, and every cycle is compared for halt timing, write order and output changes.

- **Addressing program.** A direct, an indirect and an immediate add are applied to the same operand field. The three modes can only be told apart if they produce different results: 403, 300 and 200.
- **Skip program.** A value is pushed across the signed overflow boundary, and then every skip condition is driven both ways, including the code that must never skip. A wrong sign test or a wrong increment changes the final stored value.
- **Flow program.** This program covers input, output, jump, a subroutine call, a return through jump-indirect and load-indirect. It separates the return address, the call's accumulator value and the target.
- **Halt program.** A final program halts after an output, to show that nothing moves afterwards.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 12;
  localparam int OPC_W  = 4;
  localparam int IO_W   = 8;
  localparam int OPC_LSB = WORD_W - OPC_W;
  localparam int ST_W   = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_HALT, OP_LOAD, OP_STORE, OP_ADD, OP_SUB, OP_IN, OP_OUT, OP_CALL,
    OP_SKIP, OP_JUMP, OP_CLR, OP_ADDIND, OP_JUMPIND, OP_LOADIND, OP_ADDIMM, OP_SUBIMM
  } opcode_e;

  typedef enum logic [ST_W-1:0] {
    S_F0, S_F1, S_F2, S_F3, S_EXEC,
    S_RD_WAIT, S_RD_CAP, S_RD_USE,
    S_IND_WAIT, S_IND_CAP, S_IND_USE,
    S_WR, S_CALL_WR, S_CALL_SUM, S_CALL_JMP, S_HALT
  } state_e;

  function automatic logic [WORD_W-1:0] zext_addr(input logic [ADDR_W-1:0] a);
    return {{(WORD_W-ADDR_W){1'b0}}, a};
  endfunction

  function automatic logic [WORD_W-1:0] wrap_add(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [WORD_W-1:0] wrap_sub(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
    return a - b;
  endfunction

  // 00: negative, 01: zero, 10: positive, 11: never
  function automatic logic skip_hit(input logic [1:0] cond, input logic [WORD_W-1:0] acc);
    logic is_neg, is_zero;
    is_neg  = acc[WORD_W-1];
    is_zero = (acc == '0);
    case (cond)
      2'b00:   return is_neg;
      2'b01:   return is_zero;
      2'b10:   return !is_neg && !is_zero;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  opcode_e op,
  output state_e  st,
  output logic    halted
);
  state_e st_nx;

  always_comb begin
    st_nx = st;
    case (st)
      S_F0: st_nx = S_F1;
      S_F1: st_nx = S_F2;
      S_F2: st_nx = S_F3;
      S_F3: st_nx = S_EXEC;
      S_EXEC: begin
        case (op)
          OP_HALT:  st_nx = S_HALT;
          OP_LOAD, OP_ADD, OP_SUB, OP_ADDIND, OP_JUMPIND, OP_LOADIND: st_nx = S_RD_WAIT;
          OP_STORE: st_nx = S_WR;
          OP_CALL:  st_nx = S_CALL_WR;
          default:  st_nx = S_F0;
        endcase
      end
      S_RD_WAIT:  st_nx = S_RD_CAP;
      S_RD_CAP:   st_nx = S_RD_USE;
      S_RD_USE:   st_nx = (op == OP_ADDIND || op == OP_LOADIND) ? S_IND_WAIT : S_F0;
      S_IND_WAIT: st_nx = S_IND_CAP;
      S_IND_CAP:  st_nx = S_IND_USE;
      S_IND_USE:  st_nx = S_F0;
      S_WR:       st_nx = S_F0;
      S_CALL_WR:  st_nx = S_CALL_SUM;
      S_CALL_SUM: st_nx = S_CALL_JMP;
      S_CALL_JMP: st_nx = S_F0;
      S_HALT:     st_nx = S_HALT;
      default:    st_nx = S_F0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_F0;
    else        st <= st_nx;
  end

  assign halted = (st == S_HALT);
endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath
  import acc_cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  state_e            st,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [IO_W-1:0]   in_data,
  output logic [ADDR_W-1:0] mar_o,
  output logic [WORD_W-1:0] mbr_o,
  output logic [IO_W-1:0]   out_o,
  output opcode_e           op_o
);
  logic [ADDR_W-1:0] pc, mar;
  logic [WORD_W-1:0] ir, mbr, ac;
  logic [IO_W-1:0]   out_q;
  logic [ADDR_W-1:0] fld_x;
  logic [1:0]        skip_cond;
  opcode_e           op;

  assign op        = opcode_e'(ir[WORD_W-1:OPC_LSB]);
  assign fld_x     = ir[ADDR_W-1:0];
  assign skip_cond = ir[ADDR_W-1:ADDR_W-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; mar <= '0; ir <= '0; mbr <= '0; ac <= '0; out_q <= '0;
    end else begin
      case (st)
        S_F0: mar <= pc;
        S_F1: pc  <= pc + 1'b1;
        S_F2: mbr <= mem_rdata;
        S_F3: ir  <= mbr;
        S_EXEC: begin
          case (op)
            OP_LOAD, OP_ADD, OP_SUB, OP_ADDIND, OP_JUMPIND, OP_LOADIND: mar <= fld_x;
            OP_STORE:  begin mar <= fld_x; mbr <= ac; end
            OP_IN:     ac <= {{(WORD_W-IO_W){1'b0}}, in_data};
            OP_OUT:    out_q <= ac[IO_W-1:0];
            OP_CALL:   begin mar <= fld_x; mbr <= zext_addr(pc); end
            OP_SKIP:   if (skip_hit(skip_cond, ac)) pc <= pc + 1'b1;
            OP_JUMP:   pc <= fld_x;
            OP_CLR:    ac <= '0;
            OP_ADDIMM: ac <= wrap_add(ac, zext_addr(fld_x));
            OP_SUBIMM: ac <= wrap_sub(ac, zext_addr(fld_x));
            default: ;
          endcase
        end
        S_RD_CAP:  mbr <= mem_rdata;
        S_RD_USE: begin
          case (op)
            OP_LOAD:    ac  <= mbr;
            OP_ADD:     ac  <= wrap_add(ac, mbr);
            OP_SUB:     ac  <= wrap_sub(ac, mbr);
            OP_JUMPIND: pc  <= mbr[ADDR_W-1:0];
            OP_ADDIND, OP_LOADIND: mar <= mbr[ADDR_W-1:0];
            default: ;
          endcase
        end
        S_IND_CAP: mbr <= mem_rdata;
        S_IND_USE: ac  <= (op == OP_ADDIND) ? wrap_add(ac, mbr) : mbr;
        S_CALL_WR: begin mbr <= zext_addr(fld_x); ac <= WORD_W'(1); end
        S_CALL_SUM: ac <= wrap_add(ac, mbr);
        S_CALL_JMP: pc <= ac[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  assign mar_o = mar;
  assign mbr_o = mbr;
  assign out_o = out_q;
  assign op_o  = op;

  // R2
  fetch_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EXEC) |-> (pc == mar + 1'b1));
  // R7
  skip_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EXEC && op == OP_SKIP && skip_cond == 2'b11) |=> (pc == $past(pc)));
  // R9
  call_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CALL_WR) |-> (mbr == zext_addr(pc)));
  // R9
  call_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CALL_JMP) |=> (pc == mar + 1'b1));
  // R10
  out_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> $past(st == S_EXEC && op == OP_OUT));
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [IO_W-1:0]   in_data,
  output logic [IO_W-1:0]   out_data,
  output logic              halted
);
  state_e  st;
  opcode_e op;

  acc_cpu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .op(op), .st(st), .halted(halted)
  );

  acc_cpu_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .mem_rdata(mem_rdata), .in_data(in_data),
    .mar_o(mem_addr), .mbr_o(mem_wdata), .out_o(out_data), .op_o(op)
  );

  assign mem_we = (st == S_WR) || (st == S_CALL_WR);

  // R3
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_we && $stable(out_data)));
  // R11
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!halted && !mem_we));
endmodule

// File: tb/acc_cpu_core_tb_top.sv
module acc_cpu_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_we, halted;
  logic [7:0]  in_data, out_data;

  acc_cpu_core dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .in_data(in_data),
    .out_data(out_data), .halted(halted)
  );

  logic [15:0] mem   [4096];
  logic [15:0] ref_m [4096];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  int total = 0, bad = 0;
  bit done = 0;
  int wq_a[$], wq_d[$], oq[$];
  int halt_at;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) begin mem[i] = '0; ref_m[i] = '0; end
  endtask

  task automatic poke(input int a, input int v);
    mem[a] = v[15:0]; ref_m[a] = v[15:0];
  endtask

  // Instruction-level reference: cycle costs and effects from the requirements.
  task automatic run_model(input int inval);
    int pc = 0, ac = 0, cyc = 0, ir, op, x, cnd, last_out = 0;
    bit stop = 0, neg;
    wq_a.delete(); wq_d.delete(); oq.delete(); halt_at = -1;
    for (int s = 0; s < 2000 && !stop; s++) begin
      ir = ref_m[pc]; pc = (pc + 1) % 4096; op = ir >> 12; x = ir & 'hFFF;
      case (op)
        0:  begin halt_at = cyc + 5; stop = 1; end
        1:  begin ac = ref_m[x]; cyc += 8; end
        2:  begin ref_m[x] = ac[15:0]; wq_a.push_back(x); wq_d.push_back(ac); cyc += 6; end
        3:  begin ac = (ac + ref_m[x]) & 'hFFFF; cyc += 8; end
        4:  begin ac = (ac - ref_m[x]) & 'hFFFF; cyc += 8; end
        5:  begin ac = inval & 'hFF; cyc += 5; end
        6:  begin
              if ((ac & 'hFF) != last_out) begin last_out = ac & 'hFF; oq.push_back(last_out); end
              cyc += 5;
            end
        7:  begin
              ref_m[x] = pc[15:0]; wq_a.push_back(x); wq_d.push_back(pc);
              ac = x + 1; pc = (x + 1) % 4096; cyc += 8;
            end
        8:  begin
              cnd = (x >> 10) & 3; neg = (ac >= 'h8000);
              if ((cnd == 0 && neg) || (cnd == 1 && ac == 0) || (cnd == 2 && !neg && ac != 0))
                pc = (pc + 1) % 4096;
              cyc += 5;
            end
        9:  begin pc = x; cyc += 5; end
        10: begin ac = 0; cyc += 5; end
        11: begin ac = (ac + ref_m[ref_m[x] & 'hFFF]) & 'hFFFF; cyc += 11; end
        12: begin pc = ref_m[x] & 'hFFF; cyc += 8; end
        13: begin ac = ref_m[ref_m[x] & 'hFFF]; cyc += 11; end
        14: begin ac = (ac + x) & 'hFFFF; cyc += 5; end
        default: begin ac = (ac - x) & 'hFFFF; cyc += 5; end
      endcase
    end
  endtask

  task automatic run_prog(input int inval, input int extra, output int rise);
    int stop_at;
    logic [7:0] cur_out;
    int miss;
    in_data = inval[7:0];
    run_model(inval);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(halted === 1'b0 && mem_we === 1'b0, "R1", "halted/we in reset", {halted, mem_we}, 0);
    chk(out_data === 8'h00 && mem_addr === 12'h000, "R1", "out/addr in reset", {out_data, mem_addr}, 0);
    rst_n = 1'b1;
    cur_out = 8'h00;
    rise = -1;
    stop_at = (halt_at < 0) ? 3000 : halt_at + extra;
    for (int cnt = 0; cnt <= stop_at; cnt++) begin
      if (cnt > 0) @(negedge clk);
      if (cnt == 0)
        chk(mem_addr === 12'h000 && halted === 1'b0, "R1", "first cycle addr/halted", mem_addr, 0);
      if (halted !== (cnt >= halt_at && halt_at >= 0))
        chk(0, "R3", $sformatf("halted at cycle %0d", cnt), halted, cnt >= halt_at);
      if (halted === 1'b1 && rise < 0) rise = cnt;
      if (mem_we === 1'b1) begin
        if (wq_a.size() == 0) chk(0, "R11", "unexpected write addr", mem_addr, 0);
        else begin
          chk(mem_addr == wq_a[0][11:0] && mem_wdata == wq_d[0][15:0], "R11",
              "write addr,data", {mem_addr, mem_wdata}, {wq_a[0][11:0], wq_d[0][15:0]});
          void'(wq_a.pop_front()); void'(wq_d.pop_front());
        end
      end
      if (out_data !== cur_out) begin
        if (oq.size() == 0) chk(0, "R10", "unexpected out change", out_data, cur_out);
        else begin
          chk(out_data == oq[0][7:0], "R10", "out value", out_data, oq[0]);
          void'(oq.pop_front());
        end
        cur_out = out_data;
      end
    end
    chk(wq_a.size() == 0, "R11", "writes still pending", wq_a.size(), 0);
    chk(oq.size() == 0, "R10", "outputs still pending", oq.size(), 0);
    miss = -1;
    for (int i = 0; i < 4096; i++) if (mem[i] !== ref_m[i] && miss < 0) miss = i;
    chk(miss < 0, "R4", $sformatf("memory image at %0h", miss), miss < 0 ? 0 : mem[miss],
        miss < 0 ? 0 : ref_m[miss]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      chk(0, "R2", "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rise;
    in_data = 8'h00;

    // Program 1: direct, indirect and immediate add on one operand field.
    clear_mem();
    poke(0, 'hA000); poke(1, 'h30C8); poke(2, 'h2100);
    poke(3, 'hA000); poke(4, 'hB0C8); poke(5, 'h2101);
    poke(6, 'hA000); poke(7, 'hE0C8); poke(8, 'h2102); poke(9, 'h0000);
    poke(200, 403); poke(403, 300);
    run_prog(0, 8, rise);
    chk(mem[12'h100] == 16'd403, "R4", "direct add", mem[12'h100], 403);
    chk(mem[12'h101] == 16'd300, "R5", "indirect add", mem[12'h101], 300);
    chk(mem[12'h102] == 16'd200, "R6", "immediate add", mem[12'h102], 200);
    chk(rise == 62, "R2", "halt cycle of program 1", rise, 62);

    // Program 2: wrap, subtract, every skip condition.
    clear_mem();
    poke(0, 'h1040); poke(1, 'hE001); poke(2, 'h2050); poke(3, 'h8000);
    poke(4, 'h0000); poke(5, 'hA000); poke(6, 'h8400); poke(7, 'h0000);
    poke(8, 'hF003); poke(9, 'h8800); poke(10, 'h4041); poke(11, 'h8800);
    poke(12, 'h0000); poke(13, 'h8C00); poke(14, 'h2051); poke(15, 'h0000);
    poke('h40, 'h7FFF); poke('h41, 'hFFF0);
    run_prog(0, 8, rise);
    chk(mem[12'h050] == 16'h8000, "R6", "wrap on add-immediate", mem[12'h050], 'h8000);
    chk(mem[12'h051] == 16'h000D, "R7", "skip chain result", mem[12'h051], 'h000D);

    // Program 3: input, output, jump, call/return, load-indirect.
    clear_mem();
    poke(0, 'h5000); poke(1, 'h6000); poke(2, 'h2060); poke(3, 'h9010); poke(4, 'h0000);
    poke('h10, 'h7020); poke('h11, 'h2061); poke('h12, 'hD030); poke('h13, 'h2062);
    poke('h14, 'h6000); poke('h15, 'h0000);
    poke('h21, 'h2063); poke('h22, 'hE005); poke('h23, 'hC020);
    poke('h30, 'h0031); poke('h31, 'h1234);
    run_prog('hA5, 8, rise);
    chk(mem[12'h060] == 16'h00A5, "R10", "input zero-extended", mem[12'h060], 'hA5);
    chk(mem[12'h020] == 16'h0011, "R9", "return address saved", mem[12'h020], 'h11);
    chk(mem[12'h063] == 16'h0021, "R9", "AC after call", mem[12'h063], 'h21);
    chk(mem[12'h061] == 16'h0026, "R8", "return via jump-indirect", mem[12'h061], 'h26);
    chk(mem[12'h062] == 16'h1234, "R5", "load-indirect", mem[12'h062], 'h1234);
    chk(out_data == 8'h34, "R10", "output low byte", out_data, 'h34);

    // Program 4: output then halt; nothing moves afterwards.
    clear_mem();
    poke(0, 'h5000); poke(1, 'h6000); poke(2, 'h0000);
    run_prog('h3C, 30, rise);
    chk(rise == 15, "R3", "halt cycle of program 4", rise, 15);
    chk(out_data == 8'h3C && halted == 1'b1, "R3", "held after halt", out_data, 'h3C);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule